// File: doc/BRIEF.md
# SPI Run-Stop and Power-Mode Controller

This block is the small control state machine that sits beside a serial peripheral interface shift engine and decides, cycle by cycle, whether that engine is allowed to begin a new frame. It holds one of three states: halted (STOPPED), moving data (RUNNING), and a clock-off-ready state entered on an external stop request. Several sources can ask it to halt: a software halt bit, a module-disable bit, a doze request that only counts when its doze-enable bit is set, a debug request that only counts when its freeze bit is set, and the external stop request.

No halt takes effect in the middle of a frame. The shift engine reports a frame in progress on `frame_busy`. A request that arrives while that signal is high is latched and serviced at the first cycle in which it is low. This holds even if the request is withdrawn in the meantime. While any halt is pending, no new frame may start. While a stop request is pending or active, the block also closes the register-access gate. The block leaves clock-off-ready as soon as the stop request is removed, which means the clocks are back. It then restarts once every halt source is clear.

Top module: `spi_runstop_ctrl`

## Requirements
- R1: After reset the controller is STOPPED: `running`, `xfer_en` and `stop_ack` are all low.
- R2: `xfer_en` is high only while RUNNING and only when no halt source is active or latched as pending. The halt sources are halt, disable, qualified doze, qualified freeze and stop.
- R3: From STOPPED, with `halt_sw`, `mod_dis`, qualified doze, qualified freeze and `stop_req` all low, `running` goes high at the next clock edge.
- R4: `dbg_req` with `frz_en` high halts the controller. `dbg_req` with `frz_en` low leaves `running` and `xfer_en` unchanged.
- R5: `mod_dis` high, or `doze_req` high together with `doze_en` high, halts the controller. `doze_req` with `doze_en` low has no effect.
- R6: A halt request seen while `frame_busy` is high is held pending. RUNNING is left at the first edge at which `frame_busy` is low, even if the request has been withdrawn by then.
- R7: `stop_req` takes the controller to clock-off-ready at a frame boundary. There `stop_ack` is high and `running` is low.
- R8: While `stop_req` is high, while a stop is pending, or while `stop_ack` is high, `reg_grant` stays low and `xfer_en` stays low.
- R9: When `stop_req` falls in clock-off-ready, `stop_ack` falls at the next edge and the controller is STOPPED. From there R3 applies.
- R10: `reg_grant` follows `reg_req` in STOPPED and in RUNNING whenever no stop request is active or pending.
- R11: Stop outranks start. In STOPPED, `stop_req` high with all other sources clear leads to clock-off-ready, not RUNNING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_sw | input | 1 | Software halt control |
| mod_dis | input | 1 | Module-disable bit |
| doze_req | input | 1 | Doze request from the system |
| doze_en | input | 1 | Doze-enable qualifier |
| dbg_req | input | 1 | Debug request from the system |
| frz_en | input | 1 | Freeze-on-debug qualifier |
| stop_req | input | 1 | External stop request; low means clocks are on |
| frame_busy | input | 1 | Shift engine has a frame in progress |
| reg_req | input | 1 | Register read or write requested |
| xfer_en | output | 1 | Shift engine may start a frame |
| running | output | 1 | Controller is RUNNING |
| stop_ack | output | 1 | Stop accepted, ready for clocks off |
| reg_grant | output | 1 | Register access allowed this cycle |

## Verification
The assertions check a fixed set of properties on every cycle:
- the start enable never leaves the RUNNING state;
- a qualified freeze always blocks starts;
- leaving RUNNING and raising the stop acknowledge only happen on cycles with no frame in progress;
- register access is always closed during any stop;
- every entry into RUNNING was preceded by a cycle with every halt source clear.

Some behaviours need chosen stimulus, so only the bench scenarios can show them:
- that a doze request without its enable, or a debug request without freeze, changes nothing;
- that a request pulsed and withdrawn mid-frame is still serviced at the boundary;
- the exact exit sequence from clock-off-ready;
- that stop wins over start.

// File: rtl/spi_rs_pkg.sv
// Package: shared state encoding for the SPI run-stop controller.
// Assumes: three states are sufficient; encoding is two bits.
package spi_rs_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_RUNNING = 2'd1,
        ST_CLKOFF  = 2'd2
    } rs_state_t;

endpackage

// File: rtl/rs_src_combine.sv
// Module: rs_src_combine
// Merges several halt sources, each gated by its own qualifier bit, into a
// single "halt wanted" flag. Sources without a qualifier have it tied high.
// Assumes: all inputs are synchronous to the controller clock.
module rs_src_combine #(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] src_qual,
    output logic               halt_any
);

    logic [NUM_SRC-1:0] gated;

    // Qualify each source with its enable bit.
    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            assign gated[i] = src_req[i] & src_qual[i];
        end
    endgenerate

    // Any qualified source requests a halt.
    assign halt_any = |gated;

endmodule

// File: rtl/rs_pend_latch.sv
// Module: rs_pend_latch
// Remembers a request that was seen while a frame was in progress, so it is
// honoured at the next frame boundary even if the request is withdrawn.
// Assumes: cleared whenever the controller is not RUNNING.
module rs_pend_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic in_run,
    input  logic busy,
    input  logic req,
    output logic pend
);

    // Capture mid-frame requests; drop them once RUNNING is left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (!in_run) begin
            pend <= 1'b0;
        end else if (req && busy) begin
            pend <= 1'b1;
        end
    end

endmodule

// File: rtl/rs_fsm.sv
// Module: rs_fsm
// Three-state run-stop sequencer. Halts only at frame boundaries. Stop
// requests take priority over starting, and over a plain halt.
// Assumes: halt_any and stop_req are already qualified; busy is low at
// every frame boundary.
module rs_fsm
    import spi_rs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_any,
    input  logic      stop_req,
    input  logic      gen_pend,
    input  logic      stop_pend,
    input  logic      busy,
    output rs_state_t state
);

    rs_state_t nxt;
    logic      stop_want;
    logic      halt_want;

    // Collect live and latched requests.
    assign stop_want = stop_req | stop_pend;
    assign halt_want = halt_any | gen_pend | stop_want;

    // Next-state decision.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_STOPPED: begin
                if (stop_req) begin
                    if (!busy) nxt = ST_CLKOFF;
                end else if (!halt_any) begin
                    nxt = ST_RUNNING;
                end
            end
            ST_RUNNING: begin
                if (halt_want && !busy) begin
                    nxt = stop_want ? ST_CLKOFF : ST_STOPPED;
                end
            end
            ST_CLKOFF: begin
                if (!stop_req) nxt = ST_STOPPED;
            end
            default: nxt = ST_STOPPED;
        endcase
    end

    // State register with synchronous reset to STOPPED.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STOPPED;
        else        state <= nxt;
    end

endmodule

// File: rtl/spi_runstop_ctrl.sv
// Module: spi_runstop_ctrl (top)
// Run-stop and power-mode controller for an SPI shift engine. It combines
// the qualified halt sources, latches requests made mid-frame, sequences
// the state, and drives the transfer enable and the register gate.
// Assumes: all inputs are synchronous to clk; reset is active low.
module spi_runstop_ctrl
    import spi_rs_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_sw,
    input  logic mod_dis,
    input  logic doze_req,
    input  logic doze_en,
    input  logic dbg_req,
    input  logic frz_en,
    input  logic stop_req,
    input  logic frame_busy,
    input  logic reg_req,
    output logic xfer_en,
    output logic running,
    output logic stop_ack,
    output logic reg_grant
);

    rs_state_t          state;
    logic               halt_any;
    logic               gen_pend;
    logic               stop_pend;
    logic               in_run;
    logic [NUM_SRC-1:0] src_req;
    logic [NUM_SRC-1:0] src_qual;

    // Source vector: software halt, disable, doze, debug freeze.
    assign src_req  = {halt_sw, mod_dis, doze_req, dbg_req};
    assign src_qual = {1'b1,    1'b1,    doze_en,  frz_en};
    assign in_run   = (state == ST_RUNNING);

    rs_src_combine #(.NUM_SRC(NUM_SRC)) u_comb (
        .src_req  (src_req),
        .src_qual (src_qual),
        .halt_any (halt_any)
    );

    rs_pend_latch u_gen_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_run (in_run),
        .busy   (frame_busy),
        .req    (halt_any),
        .pend   (gen_pend)
    );

    rs_pend_latch u_stop_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_run (in_run),
        .busy   (frame_busy),
        .req    (stop_req),
        .pend   (stop_pend)
    );

    rs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_any  (halt_any),
        .stop_req  (stop_req),
        .gen_pend  (gen_pend),
        .stop_pend (stop_pend),
        .busy      (frame_busy),
        .state     (state)
    );

    // Output decode: a start is allowed only with nothing asking to halt.
    assign running   = in_run;
    assign stop_ack  = (state == ST_CLKOFF);
    assign xfer_en   = in_run && !(halt_any || gen_pend || stop_req || stop_pend);
    assign reg_grant = reg_req && !stop_ack && !stop_req && !stop_pend;

endmodule

// File: rtl/spi_runstop_ctrl_chk.sv
// Module: spi_runstop_ctrl_chk
// Checker with per-cycle properties of the run-stop controller, bound to
// the top module. Observes ports only.
module spi_runstop_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic halt_sw,
    input logic mod_dis,
    input logic doze_req,
    input logic doze_en,
    input logic dbg_req,
    input logic frz_en,
    input logic stop_req,
    input logic frame_busy,
    input logic xfer_en,
    input logic running,
    input logic stop_ack,
    input logic reg_grant
);

    logic after_rst;

    // Marks the first cycle after reset was released.
    always_ff @(posedge clk) after_rst <= !rst_n;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        after_rst |-> (!running && !stop_ack && !xfer_en));

    p_xfer_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |-> running);

    p_start_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(!halt_sw && !mod_dis && !(doze_req && doze_en)
                                 && !(dbg_req && frz_en) && !stop_req));

    p_freeze_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && frz_en) |-> !xfer_en);

    p_leave_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(!frame_busy));

    p_ack_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_ack) |-> $past(!frame_busy));

    p_no_grant_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ack || stop_req) |-> (!reg_grant && !xfer_en));

    p_ack_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ack |-> !running);

endmodule

bind spi_runstop_ctrl spi_runstop_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_sw    (halt_sw),
    .mod_dis    (mod_dis),
    .doze_req   (doze_req),
    .doze_en    (doze_en),
    .dbg_req    (dbg_req),
    .frz_en     (frz_en),
    .stop_req   (stop_req),
    .frame_busy (frame_busy),
    .xfer_en    (xfer_en),
    .running    (running),
    .stop_ack   (stop_ack),
    .reg_grant  (reg_grant)
);

// File: tb/spi_runstop_ctrl_test.sv
`timescale 1ns/1ps
module spi_runstop_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_sw = 1'b1, mod_dis = 1'b0, doze_req = 1'b0, doze_en = 1'b0;
    logic dbg_req = 1'b0, frz_en = 1'b0, stop_req = 1'b0, frame_busy = 1'b0;
    logic reg_req = 1'b0;
    logic xfer_en, running, stop_ack, reg_grant;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_runstop_ctrl uut (
        .clk(clk), .rst_n(rst_n), .halt_sw(halt_sw), .mod_dis(mod_dis),
        .doze_req(doze_req), .doze_en(doze_en), .dbg_req(dbg_req),
        .frz_en(frz_en), .stop_req(stop_req), .frame_busy(frame_busy),
        .reg_req(reg_req), .xfer_en(xfer_en), .running(running),
        .stop_ack(stop_ack), .reg_grant(reg_grant)
    );

    // Compare one value; report a mismatch with its requirement tag.
    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    // Advance to the next falling edge and settle.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        step(2);
        rst_n = 1'b1;
        step(1);
        chk("R1", "running", running, 1'b0);
        chk("R1", "xfer_en", xfer_en, 1'b0);
        chk("R1", "stop_ack", stop_ack, 1'b0);
    endtask

    task automatic t_start();
        reg_req = 1'b1;
        #0.1;
        chk("R10", "grant in STOPPED", reg_grant, 1'b1);
        reg_req = 1'b0;
        halt_sw = 1'b0;
        step(1);
        chk("R3", "running after clear", running, 1'b1);
        chk("R2", "xfer_en running", xfer_en, 1'b1);
        reg_req = 1'b1;
        #0.1;
        chk("R10", "grant in RUNNING", reg_grant, 1'b1);
        reg_req = 1'b0;
    endtask

    task automatic t_debug();
        dbg_req = 1'b1;
        frz_en = 1'b0;
        step(3);
        chk("R4", "unfrozen debug running", running, 1'b1);
        chk("R4", "unfrozen debug xfer_en", xfer_en, 1'b1);
        frz_en = 1'b1;
        #0.1;
        chk("R2", "xfer_en off on freeze", xfer_en, 1'b0);
        step(1);
        chk("R4", "freeze stops", running, 1'b0);
        dbg_req = 1'b0;
        frz_en = 1'b0;
        step(1);
        chk("R3", "restart after debug", running, 1'b1);
    endtask

    task automatic t_doze();
        doze_req = 1'b1;
        doze_en = 1'b0;
        step(3);
        chk("R5", "unqualified doze running", running, 1'b1);
        chk("R5", "unqualified doze xfer_en", xfer_en, 1'b1);
        doze_en = 1'b1;
        step(1);
        chk("R5", "qualified doze stops", running, 1'b0);
        doze_req = 1'b0;
        doze_en = 1'b0;
        step(1);
        chk("R3", "restart after doze", running, 1'b1);
        mod_dis = 1'b1;
        step(1);
        chk("R5", "disable stops", running, 1'b0);
        mod_dis = 1'b0;
        step(1);
        chk("R3", "restart after disable", running, 1'b1);
    endtask

    task automatic t_pending();
        frame_busy = 1'b1;
        mod_dis = 1'b1;
        step(1);
        mod_dis = 1'b0;
        #0.1;
        chk("R6", "still running mid-frame", running, 1'b1);
        chk("R2", "no start while pending", xfer_en, 1'b0);
        step(2);
        chk("R6", "held until boundary", running, 1'b1);
        frame_busy = 1'b0;
        step(1);
        chk("R6", "stopped at boundary", running, 1'b0);
        step(1);
        chk("R3", "restart after pending", running, 1'b1);
    endtask

    task automatic t_extstop();
        frame_busy = 1'b1;
        stop_req = 1'b1;
        reg_req = 1'b1;
        #0.1;
        chk("R8", "grant blocked on request", reg_grant, 1'b0);
        chk("R8", "xfer blocked on request", xfer_en, 1'b0);
        step(2);
        chk("R7", "no ack mid-frame", stop_ack, 1'b0);
        chk("R8", "grant blocked pending", reg_grant, 1'b0);
        frame_busy = 1'b0;
        step(1);
        chk("R7", "ack at boundary", stop_ack, 1'b1);
        chk("R7", "not running in stop", running, 1'b0);
        chk("R8", "grant blocked in stop", reg_grant, 1'b0);
        stop_req = 1'b0;
        #0.1;
        chk("R8", "grant blocked while ack", reg_grant, 1'b0);
        step(1);
        chk("R9", "ack drops", stop_ack, 1'b0);
        chk("R9", "stopped after exit", running, 1'b0);
        chk("R10", "grant restored", reg_grant, 1'b1);
        reg_req = 1'b0;
        step(1);
        chk("R9", "resume running", running, 1'b1);
    endtask

    task automatic t_priority();
        halt_sw = 1'b1;
        step(1);
        chk("R11", "halted", running, 1'b0);
        halt_sw = 1'b0;
        stop_req = 1'b1;
        step(1);
        chk("R11", "stop wins over start", stop_ack, 1'b1);
        chk("R11", "not running", running, 1'b0);
        stop_req = 1'b0;
        step(1);
        chk("R9", "ack cleared", stop_ack, 1'b0);
        step(1);
        chk("R11", "runs after release", running, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_start();
        t_debug();
        t_doze();
        t_pending();
        t_extstop();
        t_priority();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule